// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block tracks one reserved memory block on behalf of a single processing element, so that load-exclusive / store-exclusive pairs can be used to build atomic read-modify-write sequences. Each request carries an operation code and a byte address. A load-exclusive reserves the aligned block that contains the address. A later store-exclusive to that block is allowed to write only if the reservation is still intact.

The reservation covers a whole granule, a power-of-two number of words. The block address is the request address rounded down to that granule. The granule size and the word size are parameters. The monitor is in one of two states: Open (no reservation) or Exclusive (one block reserved).

A store-exclusive gets its write permit in the same cycle as the request. This lets the surrounding pipeline gate the data write directly. The pass/fail status appears one cycle later and is held for the core to read. The request interface carries no data path and never applies back-pressure: a request is taken on every clock edge where `req_valid` is high. The data memory, shareability decoding and coordination between several processors are handled elsewhere.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is Open (`mon_excl`=0), `stx_status_valid`=0 and `stx_status`=1.
- R2: Operation codes on `req_op` are: 0 ordinary access, 1 load-exclusive, 2 store-exclusive, 3 clear-exclusive, 4 exception return. Codes 5 to 7 behave as ordinary access. A load-exclusive puts the monitor in Exclusive from the next cycle.
- R3: A store-exclusive raises `store_permit` in its request cycle only when the monitor is Exclusive and the address lies in the marked block. The next cycle it reports `stx_status`=0.
- R4: A store-exclusive in Open state, or to an address outside the marked block, keeps `store_permit` low and reports `stx_status`=1.
- R5: Every store-exclusive, whether it passes or fails, leaves the monitor Open.
- R6: A clear-exclusive leaves the monitor Open.
- R7: An exception return leaves the monitor Open and never Exclusive.
- R8: A load-exclusive while already Exclusive replaces the marked block with the new one. The old block no longer passes.
- R9: Ordinary accesses and idle cycles do not change the monitor state, the marked block or the held status.
- R10: `stx_status_valid` rises the cycle after a store-exclusive. It holds, together with `stx_status`, until the next accepted request of another kind. `store_permit` is never high outside a valid store-exclusive.
- R11: The marked block is the address aligned down to GRANULE_WORDS*WORD_BYTES bytes. With the defaults (8 words of 4 bytes), a load-exclusive to 0x30 lets store-exclusives to 0x20 and 0x3F pass. Stores to 0x1F and 0x40 fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted every cycle it is high |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Byte address of the request |
| store_permit | output | 1 | Store-exclusive may write this cycle |
| stx_status | output | 1 | Store-exclusive result: 0 pass, 1 fail |
| stx_status_valid | output | 1 | `stx_status` belongs to the last store-exclusive |
| mon_excl | output | 1 | Monitor is in Exclusive state |

## Verification
The bench aims at the edges of the granule: the first and last byte of the marked block, and the bytes just outside it on either side. A design that masked one bit too few or too many would pass a store it should reject, or reject one it should pass. Repeated store-exclusives after a single load-exclusive are checked. So are back-to-back load-exclusives to different blocks. A monitor that stayed Exclusive after a store, or kept the first block, would let a second store succeed. Long mixed random runs interleave ordinary accesses, idle gaps, clears and exception returns. These catch a monitor that drops its reservation on unrelated traffic, or a status register that is overwritten or loses its valid flag while nothing is issued.

// File: rtl/excl_pkg.sv
package excl_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_LDX   = 3'd1,
    OP_STX   = 3'd2,
    OP_CLR   = 3'd3,
    OP_ERET  = 3'd4
  } excl_op_e;

  // decoded one-hot-or-zero command for the current cycle
  typedef struct packed {
    logic load;   // reserve a block
    logic store;  // try a conditional write
    logic drop;   // clear or exception return
    logic any;    // any accepted request
  } excl_cmd_t;

endpackage

// File: rtl/excl_decode.sv
module excl_decode
  import excl_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] op,
  output excl_cmd_t  cmd
);
  always_comb begin
    cmd = '0;
    cmd.any = valid;
    if (valid) begin
      case (op)
        OP_LDX:  cmd.load  = 1'b1;
        OP_STX:  cmd.store = 1'b1;
        OP_CLR:  cmd.drop  = 1'b1;
        OP_ERET: cmd.drop  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/excl_block_match.sv
module excl_block_match #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] marked_base,
  output logic [ADDR_W-1:0] addr_base,
  output logic              hit
);
  logic [ADDR_W-1:0] eq_bits;

  assign addr_base = {addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    if (i < OFFS_W) begin : g_off
      assign eq_bits[i] = 1'b1;
    end else begin : g_tag
      assign eq_bits[i] = ~(addr[i] ^ marked_base[i]);
    end
  end

  assign hit = &eq_bits;
endmodule

// File: rtl/excl_state.sv
module excl_state
  import excl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  excl_cmd_t         cmd,
  input  logic [ADDR_W-1:0] new_base,
  output logic              excl,
  output logic [ADDR_W-1:0] marked_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl        <= 1'b0;
      marked_base <= '0;
    end else if (cmd.load) begin
      excl        <= 1'b1;
      marked_base <= new_base;
    end else if (cmd.store || cmd.drop) begin
      excl        <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_status.sv
module excl_status
  import excl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  excl_cmd_t cmd,
  input  logic      pass,
  output logic      status,
  output logic      status_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status       <= 1'b1;
      status_valid <= 1'b0;
    end else if (cmd.store) begin
      status       <= ~pass;
      status_valid <= 1'b1;
    end else if (cmd.any) begin
      status_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_BYTES    = 4,
  parameter int GRANULE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              store_permit,
  output logic              stx_status,
  output logic              stx_status_valid,
  output logic              mon_excl
);
  localparam int GRAN_BYTES = GRANULE_WORDS * WORD_BYTES;
  localparam int OFFS_W     = $clog2(GRAN_BYTES);

  excl_cmd_t         cmd;
  logic [ADDR_W-1:0] marked_base;
  logic [ADDR_W-1:0] addr_base;
  logic              hit;

  excl_decode u_dec (
    .valid (req_valid),
    .op    (req_op),
    .cmd   (cmd)
  );

  excl_block_match #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_match (
    .addr        (req_addr),
    .marked_base (marked_base),
    .addr_base   (addr_base),
    .hit         (hit)
  );

  excl_state #(.ADDR_W(ADDR_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .new_base    (addr_base),
    .excl        (mon_excl),
    .marked_base (marked_base)
  );

  assign store_permit = cmd.store && mon_excl && hit;

  excl_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .pass         (store_permit),
    .status       (stx_status),
    .status_valid (stx_status_valid)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              store_permit,
  input logic              stx_status,
  input logic              stx_status_valid,
  input logic              mon_excl
);
  assert_ldx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1) |=> mon_excl);

  assert_stx_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |=> (stx_status_valid && stx_status == !$past(store_permit)));

  assert_stx_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |=> !mon_excl);

  assert_clear_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) |=> !mon_excl);

  assert_eret_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |=> !mon_excl);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(mon_excl) && $stable(stx_status) && $stable(stx_status_valid)));

  assert_permit_only_stx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_permit |-> (req_valid && req_op == 3'd2 && mon_excl));
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_op           (req_op),
  .req_addr         (req_addr),
  .store_permit     (store_permit),
  .stx_status       (stx_status),
  .stx_status_valid (stx_status_valid),
  .mon_excl         (mon_excl)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
  localparam int AW = 32;
  localparam int GB = 32;  // 8 words x 4 bytes

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic          store_permit, stx_status, stx_status_valid, mon_excl;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic          m_excl = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic          m_stat = 1'b1;
  logic          m_sval = 1'b0;

  always #5 clk = ~clk;

  excl_monitor dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .store_permit(store_permit), .stx_status(stx_status),
    .stx_status_valid(stx_status_valid), .mon_excl(mon_excl)
  );

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~(AW'(GB) - 1);
  endfunction

  function automatic logic exp_permit(input logic v, input logic [2:0] op,
                                      input logic [AW-1:0] a);
    return v && op == 3'd2 && m_excl && align(a) == m_base;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic v, input logic [2:0] op);
    if (!v) return "R9";
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] op, input logic [AW-1:0] a,
                      input string tag);
    logic p;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a;
    #2;
    p = exp_permit(v, op, a);
    check(tag, "store_permit (R10)", store_permit, p);
    @(posedge clk);
    if (v) begin
      if (op == 3'd1) begin m_excl = 1'b1; m_base = align(a); end
      else if (op == 3'd2) begin m_excl = 1'b0; m_stat = ~p; m_sval = 1'b1; end
      else if (op == 3'd3 || op == 3'd4) m_excl = 1'b0;
      if (op != 3'd2) m_sval = 1'b0;
    end
    #1;
    check(tag, "mon_excl", mon_excl, m_excl);
    check(tag, "stx_status_valid (R10)", stx_status_valid, m_sval);
    if (m_sval) check(tag, "stx_status", stx_status, m_stat);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "mon_excl", mon_excl, 1'b0);
    check("R1", "stx_status_valid", stx_status_valid, 1'b0);
    check("R1", "stx_status", stx_status, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R4: store in Open state fails
    step(1, 3'd2, 32'h100, "R4");
    check("R4", "status fail", stx_status, 1'b1);
    // R11: granule edges
    step(1, 3'd1, 32'h30, "R11");
    step(1, 3'd2, 32'h20, "R11");
    check("R11", "0x20 pass", stx_status, 1'b0);
    step(1, 3'd1, 32'h30, "R11");
    step(1, 3'd2, 32'h3F, "R11");
    check("R11", "0x3F pass", stx_status, 1'b0);
    step(1, 3'd1, 32'h30, "R11");
    step(1, 3'd2, 32'h1F, "R11");
    check("R11", "0x1F fail", stx_status, 1'b1);
    step(1, 3'd1, 32'h30, "R11");
    step(1, 3'd2, 32'h40, "R11");
    check("R11", "0x40 fail", stx_status, 1'b1);
    // R5: second store after a pass fails
    step(1, 3'd1, 32'h84, "R5");
    step(1, 3'd2, 32'h88, "R3");
    step(1, 3'd2, 32'h88, "R5");
    check("R5", "second store", stx_status, 1'b1);
    // R8: replacement
    step(1, 3'd1, 32'h200, "R8");
    step(1, 3'd1, 32'h400, "R8");
    step(1, 3'd2, 32'h204, "R8");
    check("R8", "old block", stx_status, 1'b1);
    // R9: ordinary traffic and idle keep reservation; status held
    step(1, 3'd1, 32'h500, "R9");
    step(1, 3'd0, 32'h500, "R9");
    step(1, 3'd6, 32'h900, "R9");
    step(0, 3'd2, 32'h500, "R9");
    step(1, 3'd2, 32'h510, "R9");
    check("R9", "pass after plain", stx_status, 1'b0);
    step(0, 3'd1, 32'h0, "R10");
    step(0, 3'd0, 32'h0, "R10");
    check("R10", "held valid", stx_status_valid, 1'b1);
    // R6 / R7
    step(1, 3'd1, 32'h600, "R6");
    step(1, 3'd3, 32'h0, "R6");
    step(1, 3'd2, 32'h600, "R6");
    step(1, 3'd1, 32'h600, "R7");
    step(1, 3'd4, 32'h0, "R7");
    step(1, 3'd2, 32'h600, "R7");
    check("R7", "store after eret", stx_status, 1'b1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic [2:0] op;
      logic [AW-1:0] a;
      v  = ($urandom % 8) != 0;
      op = 3'($urandom % 8);
      if (($urandom % 3) == 0) op = 3'd2;
      a  = 32'h1000 + (($urandom % 4) * GB) + ($urandom % GB);
      step(v, op, a, tag_of(v, op));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule